// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block remembers where taken branches went, so that a fetch unit can guess the next fetch address before the branch is decoded. It holds up to 256 entries in 64 sets of 4 ways. The low six address bits pick a set and the remaining 26 bits are kept as a tag. Each entry carries a stored target address and a 2-bit saturating confidence counter. A counter value of zero also marks the entry as empty, so no separate occupancy bit exists. A branch enters the buffer only after it has been resolved taken, and a new entry starts at full confidence.

The lookup side is a stream input with `lk_valid` qualifying `lk_addr`. It has no ready signal: a lookup is accepted in every cycle, and its answer is combinational from the registered table in the same cycle. The update side is also valid-qualified with no back-pressure. A resolved branch is written at the clock edge where `upd_valid` is high. An update also reports the "misapplied" case, where an entry fired on instructions that did not branch. When a set is full, an allocation takes an empty way if one exists. Otherwise it takes a way picked by a free-running 8-bit LFSR.

Top module: `btb_sa`

## Requirements
- R1: After reset every counter is 0, so every lookup reports `lk_hit`=0, `lk_taken`=0 and `lk_target`=0.
- R2: The set is address bits [5:0] and the tag is address bits [31:6]. Up to 4 different tags with the same set coexist, and a tag matches in at most one way.
- R3: `lk_hit` is 1 only when `lk_valid` is 1, the tag matches and that entry's counter is non-zero. On a miss, `lk_taken` and `lk_target` are 0.
- R4: On a hit, `lk_taken` is 1 exactly when the counter is 2 or 3, and `lk_target` is the stored target.
- R5: An update that misses the table and is not taken, or is flagged misapplied, changes nothing.
- R6: An update that misses the table, is taken and is not misapplied allocates an entry with tag, target and counter 3.
- R7: A taken, not misapplied update that hits increments the counter (saturating at 3) and replaces the stored target with `upd_target`.
- R8: A not-taken, not misapplied update that hits decrements the counter. On reaching 0 the entry reads as a miss and its way becomes free.
- R9: A misapplied update that hits decrements the counter whatever `upd_taken` says, and it leaves the target unchanged.
- R10: The allocation victim is the lowest-numbered way whose counter is 0. If no such way exists, the victim is the low 2 bits of an LFSR. The LFSR resets to 8'h01 and on every clock out of reset becomes {q[6:0], q[7]^q[5]^q[4]^q[3]}. The value before the edge is the one used.
- R11: A lookup in the same cycle as an update to the same entry returns the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup address is valid |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Live entry found for the lookup |
| lk_taken | output | 1 | Prediction is taken |
| lk_target | output | 32 | Stored target of the hit entry, 0 on miss |
| upd_valid | input | 1 | Resolved branch report is valid |
| upd_addr | input | 32 | Address the resolved entry belongs to |
| upd_taken | input | 1 | Branch was resolved taken |
| upd_target | input | 32 | Resolved branch target |
| upd_misapplied | input | 1 | Entry fired on instructions that did not branch |

## Verification
The bench aims at the counter edges. It checks that a decrement to 0 really frees the entry: a design that kept a hidden occupancy flag would keep hitting. It checks that a first taken outcome predicts taken at once: a design starting at a weak state would predict wrong. It fills one set with five tags to force a replacement, so a design that evicted a live way while a free one existed, or that stepped its LFSR differently, loses a different tag. It also sends misapplied reports marked taken and same-cycle lookup/update pairs, which catch a design that trusts `upd_taken` on misapplied updates or forwards the new contents to the lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    CTR_FREE     = 2'd0,
    CTR_WEAK_NT  = 2'd1,
    CTR_WEAK_T   = 2'd2,
    CTR_STRONG_T = 2'd3
  } ctr_e;

  function automatic logic [1:0] ctr_up(input logic [1:0] c);
    return (c == CTR_STRONG_T) ? c : c + 2'd1;
  endfunction

  function automatic logic [1:0] ctr_down(input logic [1:0] c);
    return (c == CTR_FREE) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/btb_lfsr.sv
module btb_lfsr #(
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [7:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 8'h01;
    else        q <= {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  end

  assign rnd = q[OUT_W-1:0];

  // R10: a zero state would lock the generator
  a_r10_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n) q != 8'h00);
endmodule

// File: rtl/btb_match.sv
module btb_match import btb_pkg::*; #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [WAYS-1:0][1:0]       row_ctr,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            mask,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign mask[g] = (row_tag[g] == key) && (row_ctr[g] != CTR_FREE);
  end

  always_comb begin
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (mask[w]) way = WAY_W'(w);
  end

  assign hit = |mask;
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  free_mask,
  input  logic [WAY_W-1:0] rnd,
  output logic [WAY_W-1:0] victim
);
  always_comb begin
    victim = rnd;
    for (int w = WAYS - 1; w >= 0; w--)
      if (free_mask[w]) victim = WAY_W'(w);
  end

  // R10: an empty way is never passed over for a live one
  a_r10_prefer_free: assert property (@(posedge clk) disable iff (!rst_n)
    (|free_mask) |-> free_mask[victim]);
endmodule

// File: rtl/btb_sa.sv
module btb_sa import btb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_misapplied
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
  logic [WAYS-1:0][ADDR_W-1:0] tgt_q [SETS];
  logic [WAYS-1:0][1:0]        ctr_q [SETS];

  // lookup path
  logic [IDX_W-1:0] l_set;
  logic [TAG_W-1:0] l_tag;
  logic [WAYS-1:0]  l_mask;
  logic             l_hit;
  logic [WAY_W-1:0] l_way;

  assign l_set = lk_addr[IDX_W-1:0];
  assign l_tag = lk_addr[ADDR_W-1:IDX_W];

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
    .row_tag(tag_q[l_set]), .row_ctr(ctr_q[l_set]), .key(l_tag),
    .mask(l_mask), .hit(l_hit), .way(l_way)
  );

  assign lk_hit    = lk_valid && l_hit;
  assign lk_taken  = lk_hit && ctr_q[l_set][l_way][1];
  assign lk_target = lk_hit ? tgt_q[l_set][l_way] : '0;

  // update path
  logic [IDX_W-1:0] u_set;
  logic [TAG_W-1:0] u_tag;
  logic [WAYS-1:0]  u_mask;
  logic             u_hit;
  logic [WAY_W-1:0] u_way;
  logic [WAYS-1:0]  free_mask;
  logic [WAY_W-1:0] rnd, victim;
  logic             wr_en, alloc_en;
  logic [WAY_W-1:0] wr_way;
  logic [1:0]       wr_ctr;
  logic [ADDR_W-1:0] wr_tgt;

  assign u_set = upd_addr[IDX_W-1:0];
  assign u_tag = upd_addr[ADDR_W-1:IDX_W];

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_up_match (
    .row_tag(tag_q[u_set]), .row_ctr(ctr_q[u_set]), .key(u_tag),
    .mask(u_mask), .hit(u_hit), .way(u_way)
  );

  always_comb
    for (int w = 0; w < WAYS; w++) free_mask[w] = (ctr_q[u_set][w] == CTR_FREE);

  btb_lfsr #(.OUT_W(WAY_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(rnd));

  btb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .free_mask(free_mask), .rnd(rnd), .victim(victim)
  );

  assign alloc_en = upd_valid && !u_hit && upd_taken && !upd_misapplied;

  always_comb begin
    wr_en  = 1'b0;
    wr_way = u_way;
    wr_ctr = ctr_q[u_set][u_way];
    wr_tgt = tgt_q[u_set][u_way];
    if (upd_valid && u_hit) begin
      wr_en = 1'b1;
      if (upd_misapplied) wr_ctr = ctr_down(wr_ctr);
      else if (upd_taken) begin
        wr_ctr = ctr_up(wr_ctr);
        wr_tgt = upd_target;
      end else wr_ctr = ctr_down(wr_ctr);
    end else if (alloc_en) begin
      wr_en  = 1'b1;
      wr_way = victim;
      wr_ctr = CTR_STRONG_T;
      wr_tgt = upd_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        tgt_q[s] <= '0;
        ctr_q[s] <= '0;
      end
    end else if (wr_en) begin
      tag_q[u_set][wr_way] <= u_tag;
      tgt_q[u_set][wr_way] <= wr_tgt;
      ctr_q[u_set][wr_way] <= wr_ctr;
    end
  end

  // R4: a taken prediction needs a live entry behind it
  a_r4_taken_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit);
  // R2: a tag lives in at most one way of a set
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_mask));
  // R6: fresh entries start strongly taken
  a_r6_alloc_strong: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> ctr_q[$past(u_set)][$past(victim)] == 2'd3);
  // R5: misses that do not allocate leave the row alone
  a_r5_miss_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !u_hit && (!upd_taken || upd_misapplied))
      |=> ctr_q[$past(u_set)] == $past(ctr_q[u_set]));
  // R7: taken hit refreshes the target
  a_r7_target_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && u_hit && upd_taken && !upd_misapplied)
      |=> tgt_q[$past(u_set)][$past(u_way)] == $past(upd_target));
  // R8: not-taken hit loses one step of confidence
  a_r8_nt_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && u_hit && !upd_taken && !upd_misapplied)
      |=> ctr_q[$past(u_set)][$past(u_way)] == $past(ctr_q[u_set][u_way]) - 2'd1);
  // R9: misapplied hit keeps its target
  a_r9_misapplied_keeps_target: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && u_hit && upd_misapplied)
      |=> tgt_q[$past(u_set)][$past(u_way)] == $past(tgt_q[u_set][u_way]));
endmodule

// File: tb/btb_sa_tb.sv
module btb_sa_tb_top;
  localparam int NS = 64;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic        upd_misapplied = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  btb_sa dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_misapplied(upd_misapplied)
  );

  // behavioural reference state
  int          m_ctr [NS][NW];
  logic [25:0] m_tag [NS][NW];
  logic [31:0] m_tgt [NS][NW];
  logic [7:0]  m_lfsr;

  function automatic int m_find(input logic [31:0] a);
    for (int w = 0; w < NW; w++)
      if (m_ctr[a[5:0]][w] != 0 && m_tag[a[5:0]][w] == a[31:6]) return w;
    return -1;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_ctr[s][w] = 0; m_tag[s][w] = '0; m_tgt[s][w] = '0;
      end
    m_lfsr = 8'h01;
  endtask

  task automatic m_clock(input logic v, input logic [31:0] a, input logic t,
                         input logic [31:0] tg, input logic mis);
    int s, w;
    s = a[5:0];
    w = m_find(a);
    if (v) begin
      if (w >= 0) begin
        if (mis || !t) begin
          if (m_ctr[s][w] > 0) m_ctr[s][w]--;
        end else begin
          if (m_ctr[s][w] < 3) m_ctr[s][w]++;
          m_tgt[s][w] = tg;
        end
      end else if (t && !mis) begin
        int vw;
        vw = -1;
        for (int k = NW - 1; k >= 0; k--) if (m_ctr[s][k] == 0) vw = k;
        if (vw < 0) vw = int'(m_lfsr[1:0]);
        m_ctr[s][vw] = 3; m_tag[s][vw] = a[31:6]; m_tgt[s][vw] = tg;
      end
    end
    m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
  endtask

  // one cycle: called at a negedge, drives, checks before the edge, models the edge
  task automatic cycle(input string req, input logic lv, input logic [31:0] la,
                       input logic uv, input logic [31:0] ua, input logic ut,
                       input logic [31:0] utg, input logic um);
    logic e_hit, e_tk;
    logic [31:0] e_tgt;
    int w;
    lk_valid = lv; lk_addr = la;
    upd_valid = uv; upd_addr = ua; upd_taken = ut; upd_target = utg; upd_misapplied = um;
    #1;
    w = m_find(la);
    e_hit = lv && (w >= 0);
    e_tk  = e_hit && (m_ctr[la[5:0]][w] >= 2);
    e_tgt = e_hit ? m_tgt[la[5:0]][w] : 32'h0;
    checks++;
    if (lk_hit !== e_hit || lk_taken !== e_tk || lk_target !== e_tgt) begin
      fails++;
      $display("FAIL %s addr=%h got hit=%b taken=%b tgt=%h exp hit=%b taken=%b tgt=%h",
               req, la, lk_hit, lk_taken, lk_target, e_hit, e_tk, e_tgt);
    end
    @(posedge clk);
    m_clock(uv, ua, ut, utg, um);
    @(negedge clk);
  endtask

  task automatic look(input string req, input logic [31:0] a);
    cycle(req, 1'b1, a, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic upd(input string req, input logic [31:0] a, input logic t,
                     input logic [31:0] tg, input logic mis);
    cycle(req, 1'b1, a, 1'b1, a, t, tg, mis);
  endtask

  function automatic logic [31:0] mk(input int tag, input int set);
    return {26'(tag), 6'(set)};
  endfunction

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    look("R1", mk(0, 0));
    look("R1", mk(123, 17));
    look("R1", 32'hFFFF_FFFF);
    // R5: not-taken miss and misapplied miss allocate nothing
    upd("R5", mk(9, 7), 1'b0, 32'h0000_1111, 1'b0);
    upd("R5", mk(9, 7), 1'b1, 32'h0000_1111, 1'b1);
    look("R5", mk(9, 7));
    // R6 + R11: allocation, same-cycle lookup shows old contents
    upd("R11", mk(9, 7), 1'b1, 32'hA000_0040, 1'b0);
    look("R6", mk(9, 7));
    look("R2", mk(10, 7));
    // R8 + R4: weaken to 1 then free
    upd("R8", mk(9, 7), 1'b0, 32'h0, 1'b0);
    look("R4", mk(9, 7));
    upd("R8", mk(9, 7), 1'b0, 32'h0, 1'b0);
    look("R4", mk(9, 7));
    upd("R8", mk(9, 7), 1'b0, 32'h0, 1'b0);
    look("R8", mk(9, 7));
    // R7: reallocate, saturate, target refresh
    upd("R6", mk(9, 7), 1'b1, 32'hB000_0000, 1'b0);
    upd("R7", mk(9, 7), 1'b1, 32'hC000_0000, 1'b0);
    upd("R7", mk(9, 7), 1'b1, 32'hD000_0000, 1'b0);
    look("R7", mk(9, 7));
    upd("R8", mk(9, 7), 1'b0, 32'h0, 1'b0);
    look("R7", mk(9, 7));
    // R9: misapplied with taken set still decrements, target kept
    upd("R9", mk(9, 7), 1'b1, 32'hEEEE_EEEE, 1'b1);
    look("R9", mk(9, 7));
    upd("R9", mk(9, 7), 1'b1, 32'hEEEE_EEEE, 1'b1);
    look("R9", mk(9, 7));
    // R2 + R10: fill one set, then force replacement
    for (int t = 1; t <= 4; t++) upd("R2", mk(t, 33), 1'b1, 32'h100 * t, 1'b0);
    for (int t = 1; t <= 4; t++) look("R2", mk(t, 33));
    upd("R10", mk(5, 33), 1'b1, 32'h500, 1'b0);
    for (int t = 1; t <= 5; t++) look("R10", mk(t, 33));
    // free one way, the next allocation must reuse it
    upd("R8", mk(2, 33), 1'b0, 32'h0, 1'b0);
    upd("R8", mk(2, 33), 1'b0, 32'h0, 1'b0);
    upd("R8", mk(2, 33), 1'b0, 32'h0, 1'b0);
    upd("R10", mk(6, 33), 1'b1, 32'h600, 1'b0);
    for (int t = 1; t <= 6; t++) look("R10", mk(t, 33));
    // R3: invalid lookup never hits
    cycle("R3", 1'b0, mk(6, 33), 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    // mixed traffic on a crowded pool of sets and tags
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] la, ua;
      la = mk($urandom_range(0, 5), $urandom_range(0, 2));
      ua = ($urandom_range(0, 3) == 0) ? la : mk($urandom_range(0, 5), $urandom_range(0, 2));
      cycle("R2/R3/R4/R6/R7/R8/R9/R10/R11", $urandom_range(0, 7) != 0, la,
            $urandom_range(0, 1) == 1, ua, $urandom_range(0, 2) != 0,
            $urandom(), $urandom_range(0, 5) == 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule